// File: doc/BRIEF.md
# Saturating Seven-State Up/Down Counter

This block is a synchronous counter with seven legal states, numbered 0 to 6. It moves one state on every clock edge. A direction input chooses whether it moves up or down. At either end it holds its position and does not wrap, so repeated down steps park it at state 0 and repeated up steps park it at state 6.

A build-time parameter picks the state code. One choice is a reflected Gray assignment, in which neighbouring states differ in one bit. The other is a direct binary assignment. The state register is made of toggle flip-flops. The control logic therefore produces one toggle-enable per bit, not next-state values. Each encoding has one 3-bit pattern that names no state, and a register holding that pattern returns to state 0 on the next edge.

Besides the raw code, the block gives a decoded state index. This index is the same for both encodings, so logic downstream does not depend on the chosen code.

Top module: `sat7_counter`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, that edge loads state 0 (index 0, code 000 in both encodings).
- R2: With `countUp` high and the state below 6, each clock edge raises the index by exactly one.
- R3: With `countUp` low and the state above 0, each clock edge lowers the index by exactly one.
- R4: With `countUp` low in state 0, the next edge leaves the counter in state 0.
- R5: With `countUp` high in state 6, the next edge leaves the counter in state 6.
- R6: With `GRAY_ENC`=1, states 0..6 carry the codes 000, 001, 011, 010, 110, 111, 101, and 100 is the unused code.
- R7: With `GRAY_ENC`=0, the code of state i is i in plain binary (000..110), and 111 is the unused code.
- R8: With `GRAY_ENC`=1, one clock edge changes at most one code bit.
- R9: `stateIdx` always gives the index 0..6 of the current state, whichever encoding is selected.
- R10: The unused code never shows on `stateCode` after reset. If the register ever held it, the next edge would load state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to state 0 |
| countUp | input | 1 | 1 = step up, 0 = step down |
| stateCode | output | 3 | Encoded state register contents |
| stateIdx | output | 3 | Decoded state index, 0 to 6 |

## Verification
A wrong toggle enable changes the register at the very edge where it occurs. It shows up one cycle later as a `stateCode` that does not match the code table. For a wrong Gray step, it shows as a jump of more than one bit. A fault in decoding shows at once on `stateIdx`, which is compared with the index the model expects on every cycle. A saturation error shows on the first edge at an end state, because the index moves off 0 or 6 or wraps. Both encodings run side by side on the same stimulus, so a fault that affects only one encoding is still visible.

// File: rtl/sat7_pkg.sv
package sat7_pkg;
  localparam int STATE_W    = 3;
  localparam int NUM_STATES = 7;
  localparam logic [STATE_W-1:0] LAST_IDX = STATE_W'(NUM_STATES - 1);

  // Per-bit toggle enables handed from control to datapath
  typedef struct packed {
    logic [STATE_W-1:0] tglEn;
  } ctlStrobes_t;

  // Index -> register code
  function automatic logic [STATE_W-1:0] encodeIdx(input logic [STATE_W-1:0] idx,
                                                   input bit useGray);
    return useGray ? (idx ^ (idx >> 1)) : idx;
  endfunction

  // Register code -> index; the unused code of either encoding maps to 7
  function automatic logic [STATE_W-1:0] decodeCode(input logic [STATE_W-1:0] code,
                                                    input bit useGray);
    logic [STATE_W-1:0] bin;
    if (useGray) begin
      bin[STATE_W-1] = code[STATE_W-1];
      for (int i = STATE_W - 2; i >= 0; i--) bin[i] = bin[i+1] ^ code[i];
    end else begin
      bin = code;
    end
    return bin;
  endfunction
endpackage

// File: rtl/sat7_ctrl.sv
module sat7_ctrl
  import sat7_pkg::*;
#(
  parameter bit GRAY_ENC = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               countUp,
  input  logic [STATE_W-1:0] stateCode,
  output ctlStrobes_t        strobes
);
  logic [STATE_W-1:0] curIdx;
  logic [STATE_W-1:0] nextIdx;
  logic               codeUnused;

  always_comb begin
    curIdx     = decodeCode(stateCode, GRAY_ENC);
    codeUnused = (curIdx > LAST_IDX);
    if (codeUnused)
      nextIdx = '0;
    else if (countUp)
      nextIdx = (curIdx == LAST_IDX) ? curIdx : curIdx + STATE_W'(1);
    else
      nextIdx = (curIdx == '0) ? curIdx : curIdx - STATE_W'(1);
    strobes.tglEn = stateCode ^ encodeIdx(nextIdx, GRAY_ENC);
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (curIdx < LAST_IDX && countUp) |=> (curIdx == $past(curIdx) + STATE_W'(1))); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (curIdx > '0 && curIdx <= LAST_IDX && !countUp) |=> (curIdx == $past(curIdx) - STATE_W'(1))); // R3
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (curIdx == '0 && !countUp) |=> (curIdx == '0)); // R4
  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (curIdx == LAST_IDX && countUp) |=> (curIdx == LAST_IDX)); // R5
endmodule

// File: rtl/sat7_dpath.sv
module sat7_dpath
  import sat7_pkg::*;
#(
  parameter bit GRAY_ENC = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobes_t        strobes,
  output logic [STATE_W-1:0] stateCode,
  output logic [STATE_W-1:0] stateIdx
);
  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] rawIdx;

  // One toggle flip-flop per state bit
  for (genvar b = 0; b < STATE_W; b++) begin : g_tff
    always_ff @(posedge clk) begin
      if (rst) stateQ[b] <= 1'b0;
      else     stateQ[b] <= stateQ[b] ^ strobes.tglEn[b];
    end
  end

  always_comb begin
    rawIdx    = decodeCode(stateQ, GRAY_ENC);
    stateIdx  = (rawIdx > LAST_IDX) ? '0 : rawIdx;
    stateCode = stateQ;
  end

  AST_RESET_S0: assert property (@(posedge clk)
    rst |=> (stateQ == '0)); // R1
  AST_NO_UNUSED: assert property (@(posedge clk) disable iff (rst)
    (rawIdx <= LAST_IDX)); // R10
  AST_UNUSED_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (rawIdx > LAST_IDX) |=> (stateQ == '0)); // R10

  if (GRAY_ENC) begin : g_grayChk
    AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $onehot0(stateQ ^ $past(stateQ))); // R8
  end
endmodule

// File: rtl/sat7_counter.sv
module sat7_counter
  import sat7_pkg::*;
#(
  parameter bit GRAY_ENC = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               countUp,
  output logic [STATE_W-1:0] stateCode,
  output logic [STATE_W-1:0] stateIdx
);
  ctlStrobes_t        strobes;
  logic [STATE_W-1:0] codeQ;

  sat7_ctrl #(.GRAY_ENC(GRAY_ENC)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .countUp  (countUp),
    .stateCode(codeQ),
    .strobes  (strobes)
  );

  sat7_dpath #(.GRAY_ENC(GRAY_ENC)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .stateCode(codeQ),
    .stateIdx (stateIdx)
  );

  assign stateCode = codeQ;
endmodule

// File: tb/sat7_counter_tb.sv
module sat7_counter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic countUp = 1'b0;
  logic [2:0] grayCode, grayIdx, binCode, binIdx;

  always #4 clk = ~clk; // 125 MHz

  sat7_counter #(.GRAY_ENC(1'b1)) u_dut (
    .clk(clk), .rst(rst), .countUp(countUp), .stateCode(grayCode), .stateIdx(grayIdx));
  sat7_counter #(.GRAY_ENC(1'b0)) u_dutBin (
    .clk(clk), .rst(rst), .countUp(countUp), .stateCode(binCode), .stateIdx(binIdx));

  typedef struct {
    logic [2:0] idx;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  int         errors = 0;
  int         checks = 0;
  logic [2:0] modelIdx = 3'd0;
  logic [2:0] grayTab [7] = '{3'b000, 3'b001, 3'b011, 3'b010, 3'b110, 3'b111, 3'b101};
  bit         havePrev = 1'b0;
  logic [2:0] prevGray;
  logic [2:0] prevIdx;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: set inputs away from the edge, push the post-edge expectation
  task automatic stepOnce(input bit up, input bit doRst);
    expItem_t it;
    @(negedge clk);
    rst     = doRst;
    countUp = up;
    if (doRst)                      begin modelIdx = 3'd0; it.tag = "R1"; end
    else if (up && modelIdx == 3'd6)  it.tag = "R5";
    else if (up)                    begin modelIdx = modelIdx + 3'd1; it.tag = "R2"; end
    else if (modelIdx == 3'd0)        it.tag = "R4";
    else                            begin modelIdx = modelIdx - 3'd1; it.tag = "R3"; end
    it.idx = modelIdx;
    expQ.push_back(it);
  endtask

  // Monitor: compare shortly after each edge
  always @(posedge clk) begin
    expItem_t it;
    #2;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      check(grayIdx == it.idx, it.tag, "gray index", grayIdx, it.idx);
      check(binIdx == it.idx, "R9", "binary index", binIdx, it.idx);
      check(grayCode == grayTab[it.idx], "R6", "gray code", grayCode, grayTab[it.idx]);
      check(binCode == it.idx, "R7", "binary code", binCode, it.idx);
      check(grayCode != 3'b100 && binCode != 3'b111, "R10", "unused code seen",
            grayCode, grayTab[it.idx]);
      if (havePrev && it.tag != "R1")
        check($countones(grayCode ^ prevGray) == ((it.idx != prevIdx) ? 1 : 0), "R8",
              "gray bit changes", grayCode, prevGray);
      prevGray = grayCode;
      prevIdx  = it.idx;
      havePrev = 1'b1;
    end
  end

  initial begin : watchdog
    #(8 * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    stepOnce(1'b0, 1'b1);                                 // R1 reset state
    stepOnce(1'b0, 1'b0);                                 // R4 hold at 0
    for (int i = 0; i < 8; i++) stepOnce(1'b1, 1'b0);     // R2 then R5
    for (int i = 0; i < 9; i++) stepOnce(1'b0, 1'b0);     // R3 then R4
    for (int i = 0; i < 12; i++) stepOnce(i % 3 != 2, 1'b0); // mixed pattern
    stepOnce(1'b1, 1'b1);                                 // R1 mid-count reset
    for (int i = 0; i < 4; i++) stepOnce(i[0], 1'b0);     // alternate near 0
    @(negedge clk);
    wait (expQ.size() == 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule